// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 40-bit physical address. It walks a radix tree of page tables that lives in memory. The tree has four levels, and each table holds 512 entries of 8 bytes. A requester offers a virtual address together with the frame number of the top-level table. The walker then fetches one entry per level through a single-outstanding read port, highest level first. Each level is indexed by its own 9-bit slice of the virtual address.

At every level the walker tests the entry's valid flag. A valid entry at an upper level names the frame of the next table. A valid entry at the last level names the physical frame, and the walker joins that frame to the 12-bit page offset. A clear valid flag at any level stops the walk at once and reports a page fault. The result stays on the outputs until the requester acknowledges it, and only then does the walker take a new address.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: The address of each entry read is `{table_frame, index, 3'b000}`, which equals the table base plus index times 8. The first read uses `root_frame` as the table frame and virtual address bits 47:39 as the index.
- R3: The reads go from the top level down. The indices used are VA[47:39], then VA[38:30], then VA[29:21], then VA[20:12]. Each lower table frame is taken from bits 39:12 of the entry read one level above.
- R4: The walker has at most one read outstanding. After a read is accepted, no new read is issued until its response arrives, and a translation that succeeds makes exactly four reads.
- R5: A read request that is not accepted (`mem_req_valid` high, `mem_req_ready` low) stays asserted with an unchanged address in the next cycle.
- R6: When the walk succeeds, `res_fault` is 0 and `res_paddr` is `{last-level entry bits 39:12, VA[11:0]}`.
- R7: An entry with bit 0 clear at any level ends the walk with `res_fault` = 1 and `res_paddr` = 0. No further reads follow, so a fault at the top level makes one read and a fault at the last level makes four.
- R8: While `res_valid` is high and `res_ack` is low, `res_valid`, `res_fault` and `res_paddr` hold their values.
- R9: `req_ready` is high only when no walk is in progress and no result is pending. A request offered at any other time is ignored and does not change the result of the walk under way.
- R10: The cycle after a result is acknowledged, `res_valid` is 0 and `req_ready` is 1.
- R11: Entry bits 63:40 and 11:1 do not affect the walk or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 48 | Virtual address to translate |
| root_frame | input | 28 | Frame number of the top-level table, sampled with the request |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Translation result available |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_paddr | output | 40 | Physical address (0 on fault) |
| res_ack | input | 1 | Requester consumes the result |

## Verification
The bench places faults at the top, middle and last levels and counts the reads for each. A walker that kept going after an invalid entry would make extra reads, and one that stopped late would report a frame where a fault is due. Two translations share their upper tables and differ only in the last index, and the same address is also walked under a second root. A slice taken from the wrong bits, or a base not carried down from the level above, therefore shows up as a mismatched read address. Entries carry junk in their reserved bits, so a frame taken from the wrong field changes the address. A memory that holds off acceptance on alternate cycles exposes a request that drops or moves its address before it is accepted. A request offered in the middle of a walk exposes a walker that is ready too early, because that walker would restart or mix the two addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_BUSY = 2'd1,
        WALK_DONE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/ptw_index_sel.sv
// Picks the 9-bit table index for the current level and forms the entry address.
module ptw_index_sel #(
    parameter int LEVELS      = 4,
    parameter int IDX_W       = 9,
    parameter int FRAME_W     = 28,
    parameter int ENTRY_SHIFT = 3,
    localparam int LVL_W      = $clog2(LEVELS),
    localparam int VPN_W      = LEVELS * IDX_W,
    localparam int PA_W       = FRAME_W + IDX_W + ENTRY_SHIFT
) (
    input  logic [VPN_W-1:0]   vpn,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [FRAME_W-1:0] table_frame,
    output logic [PA_W-1:0]    entry_addr
);

    logic [IDX_W-1:0] idx_arr [LEVELS];

    // Level 0 is the last table; the highest level uses the top slice.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_arr[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        entry_addr = {table_frame, idx_arr[lvl], {ENTRY_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/ptw_entry_decode.sv
// Splits a table entry into its valid flag and frame number.
module ptw_entry_decode #(
    parameter int PTE_W = 64,
    parameter int PA_W  = 40,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0]      pte,
    output logic                  present,
    output logic [PA_W-OFF_W-1:0] frame
);

    logic unused_pte_bits;

    assign present         = pte[0];
    assign frame           = pte[PA_W-1:OFF_W];
    assign unused_pte_bits = ^{pte[PTE_W-1:PA_W], pte[OFF_W-1:1]};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS       = 4,
    parameter int IDX_W        = 9,
    parameter int PA_W         = 40,
    parameter int PTE_W        = 64,
    localparam int ENTRY_SHIFT = $clog2(PTE_W / 8),
    localparam int OFF_W       = IDX_W + ENTRY_SHIFT,
    localparam int VA_W        = OFF_W + LEVELS * IDX_W,
    localparam int FRAME_W     = PA_W - OFF_W,
    localparam int LVL_W       = $clog2(LEVELS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               res_valid,
    output logic               res_fault,
    output logic [PA_W-1:0]    res_paddr,
    input  logic               res_ack
);

    typedef struct packed {
        walk_state_e        state;
        logic [LVL_W-1:0]   lvl;
        logic               sent;
        logic [VA_W-1:0]    vaddr;
        logic [FRAME_W-1:0] frame;
        logic               fault;
        logic [PA_W-1:0]    paddr;
    } walk_regs_t;

    localparam walk_regs_t REGS_RESET = '{
        state: WALK_IDLE, lvl: '0, sent: 1'b0, vaddr: '0,
        frame: '0, fault: 1'b0, paddr: '0
    };

    walk_regs_t regs_d, regs_q;

    logic               pte_present;
    logic [FRAME_W-1:0] pte_frame;

    ptw_index_sel #(
        .LEVELS      (LEVELS),
        .IDX_W       (IDX_W),
        .FRAME_W     (FRAME_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_index_sel (
        .vpn         (regs_q.vaddr[VA_W-1:OFF_W]),
        .lvl         (regs_q.lvl),
        .table_frame (regs_q.frame),
        .entry_addr  (mem_req_addr)
    );

    ptw_entry_decode #(
        .PTE_W (PTE_W),
        .PA_W  (PA_W),
        .OFF_W (OFF_W)
    ) u_entry_decode (
        .pte     (mem_rsp_data),
        .present (pte_present),
        .frame   (pte_frame)
    );

    assign req_ready     = (regs_q.state == WALK_IDLE);
    assign mem_req_valid = (regs_q.state == WALK_BUSY) && !regs_q.sent;
    assign res_valid     = (regs_q.state == WALK_DONE);
    assign res_fault     = regs_q.fault;
    assign res_paddr     = regs_q.paddr;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    regs_d.state = WALK_BUSY;
                    regs_d.lvl   = LVL_W'(LEVELS - 1);
                    regs_d.sent  = 1'b0;
                    regs_d.vaddr = req_vaddr;
                    regs_d.frame = root_frame;
                    regs_d.fault = 1'b0;
                    regs_d.paddr = '0;
                end
            end
            WALK_BUSY: begin
                if (!regs_q.sent) begin
                    if (mem_req_ready) regs_d.sent = 1'b1;
                end else if (mem_rsp_valid) begin
                    if (!pte_present) begin
                        regs_d.state = WALK_DONE;
                        regs_d.fault = 1'b1;
                        regs_d.paddr = '0;
                    end else if (regs_q.lvl == '0) begin
                        regs_d.state = WALK_DONE;
                        regs_d.paddr = {pte_frame, regs_q.vaddr[OFF_W-1:0]};
                    end else begin
                        regs_d.lvl   = regs_q.lvl - 1'b1;
                        regs_d.frame = pte_frame;
                        regs_d.sent  = 1'b0;
                    end
                end
            end
            WALK_DONE: begin
                if (res_ack) regs_d.state = WALK_IDLE;
            end
            default: regs_d = REGS_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == WALK_BUSY && regs_q.sent && mem_rsp_valid && !pte_present)
        |=> (res_valid && res_fault && res_paddr == '0 && !mem_req_valid));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ack) |=> (res_valid && $stable(res_paddr) && $stable(res_fault)));

    // R9
    ready_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !res_valid));

    // R10
    ack_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ack) |=> (req_ready && !res_valid));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [27:0] root_frame = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_fault;
    logic [39:0] res_paddr;
    logic        res_ack = 1'b0;

    always #5 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .root_frame(root_frame),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr),
        .res_ack(res_ack)
    );

    typedef struct {
        logic        fault;
        logic [39:0] paddr;
        int          nreads;
    } exp_t;

    logic [63:0] mem [logic [39:0]];
    exp_t        exp_q [$];
    logic [39:0] addr_q [$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          rd_cnt = 0;
    int          lat = 1;
    bit          stall = 1'b0;
    int          pend = 0;
    logic [63:0] rd_data = '0;
    logic [27:0] next_tbl = 28'h00100;
    bit          res_seen = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] ent_addr(input logic [27:0] base, input logic [47:0] va, input int l);
        logic [8:0] idx;
        idx = va[12 + 9*l +: 9];
        return {base, idx, 3'b000};
    endfunction

    // Entries carry junk in bits 63:40 and 11:1 (R11).
    function automatic logic [63:0] mk_pte(input logic [27:0] frame, input bit v);
        return {24'hA5C3E1, frame, 11'h5AA, v};
    endfunction

    task automatic map_page(input logic [27:0] root, input logic [47:0] va, input logic [27:0] frame);
        logic [27:0] base;
        logic [39:0] a;
        base = root;
        for (int l = 3; l >= 1; l--) begin
            a = ent_addr(base, va, l);
            if (mem.exists(a) && mem[a][0]) base = mem[a][39:12];
            else begin
                mem[a] = mk_pte(next_tbl, 1'b1);
                base = next_tbl;
                next_tbl++;
            end
        end
        mem[ent_addr(base, va, 0)] = mk_pte(frame, 1'b1);
    endtask

    // Independent model of the walk; queues expected read addresses.
    task automatic model(input logic [47:0] va, input logic [27:0] root, output exp_t e);
        logic [27:0] base;
        logic [39:0] a;
        logic [63:0] pte;
        base = root;
        e.fault = 1'b0; e.paddr = '0; e.nreads = 0;
        for (int l = 3; l >= 0; l--) begin
            a = ent_addr(base, va, l);
            addr_q.push_back(a);
            e.nreads++;
            pte = mem.exists(a) ? mem[a] : 64'h0;
            if (!pte[0]) begin
                e.fault = 1'b1;
                return;
            end
            base = pte[39:12];
        end
        e.paddr = {base, va[11:0]};
    endtask

    // Memory responder: checks each read address against the model (R2, R3).
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid = 1'b0;
            pend = 0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd_data;
                end
            end
            mem_req_ready = stall ? ~mem_req_ready : 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                rd_cnt++;
                if (addr_q.size() == 0) begin
                    chk(1'b0, "R7 read after end of walk", {24'h0, mem_req_addr}, 64'h0);
                end else begin
                    logic [39:0] ea;
                    ea = addr_q.pop_front();
                    chk(mem_req_addr == ea, "R2/R3 entry address", {24'h0, mem_req_addr}, {24'h0, ea});
                end
                rd_data = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                pend = lat;
            end
        end
    end

    // Monitor: pops the scoreboard when a result appears (R6, R7, R4).
    always @(negedge clk) begin
        if (rst_n && res_valid && !res_seen) begin
            exp_t e;
            res_seen = 1'b1;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected result", {24'h0, res_paddr}, 64'h0);
            end else begin
                e = exp_q.pop_front();
                chk(res_fault == e.fault, "R6/R7 fault flag", {63'h0, res_fault}, {63'h0, e.fault});
                chk(res_paddr == e.paddr, "R6/R7 physical address", {24'h0, res_paddr}, {24'h0, e.paddr});
                chk(rd_cnt == e.nreads, "R4/R7 read count", rd_cnt, e.nreads);
            end
        end else if (!res_valid) begin
            res_seen = 1'b0;
        end
    end

    // Driver: pushes the expected item, then runs one translation.
    task automatic translate(input logic [47:0] va, input logic [27:0] root,
                             input int latency, input bit stl, input bit poke);
        exp_t e;
        logic [39:0] held;
        model(va, root, e);
        exp_q.push_back(e);
        lat = latency;
        stall = stl;
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; root_frame = root;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1;
            req_vaddr = ~va;
            root_frame = ~root;
            @(negedge clk);
            chk(req_ready == 1'b0, "R9 ready low while walking", {63'h0, req_ready}, 64'h0);
        end
        while (!res_valid) @(negedge clk);
        req_valid = 1'b0;
        held = res_paddr;
        @(negedge clk);
        chk(res_valid && res_paddr == held, "R8 result held", {24'h0, res_paddr}, {24'h0, held});
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(!res_valid && req_ready, "R10 idle after ack", {62'h0, res_valid, req_ready}, 64'h1);
        chk(addr_q.size() == 0, "R4/R7 no missing reads", addr_q.size(), 0);
        addr_q.delete();
        stall = 1'b0;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [27:0] ra, rb;
        ra = 28'h00010;
        rb = 28'h00020;
        repeat (2) @(negedge clk);
        // R1
        chk(req_ready == 1'b0 || req_ready == 1'b1, "R1 ready known", {63'h0, req_ready}, 64'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {63'h0, req_ready}, 64'h1);
        chk(!mem_req_valid && !res_valid, "R1 no activity after reset",
            {62'h0, mem_req_valid, res_valid}, 64'h0);

        map_page(ra, 48'h0000_1234_5678, 28'h00ABCDE);
        map_page(ra, 48'h0000_1234_6678, 28'h0001234);
        map_page(ra, 48'hFFFF_FFFF_FABC, 28'hFFFFFFF);
        map_page(ra, 48'h0000_0000_0000, 28'h0000001);
        map_page(rb, 48'h0000_1234_5678, 28'h00BEEF0);
        map_page(ra, 48'h0000_4000_0ABC, 28'h0777777);
        // Clear the valid flag at the second-to-last level, keeping its frame bits (R7).
        begin
            logic [27:0] b;
            logic [39:0] a;
            b = ra;
            for (int l = 3; l >= 2; l--) b = mem[ent_addr(b, 48'h0000_4000_0ABC, l)][39:12];
            a = ent_addr(b, 48'h0000_4000_0ABC, 1);
            mem[a] = mk_pte(mem[a][39:12], 1'b0);
        end

        // R2 R3 R6 R11: mapped pages, several index patterns
        translate(48'h0000_1234_5678, ra, 1, 1'b0, 1'b0);
        translate(48'h0000_1234_6678, ra, 3, 1'b0, 1'b0);
        translate(48'hFFFF_FFFF_FABC, ra, 2, 1'b0, 1'b0);
        translate(48'h0000_0000_0000, ra, 1, 1'b0, 1'b0);
        // R3: same address under another root
        translate(48'h0000_1234_5678, rb, 1, 1'b0, 1'b0);
        // R7: faults at top, middle and last levels
        translate(48'h8000_0000_0000, ra, 1, 1'b0, 1'b0);
        translate(48'h0000_4000_0ABC, ra, 2, 1'b0, 1'b0);
        translate(48'h0000_1234_7678, ra, 1, 1'b0, 1'b0);
        // R5: memory withholds acceptance on alternate cycles
        translate(48'hFFFF_FFFF_FABC, ra, 2, 1'b1, 1'b0);
        translate(48'h0000_4000_0ABC, ra, 1, 1'b1, 1'b0);
        // R9: request offered mid-walk is ignored
        translate(48'h0000_1234_6678, ra, 4, 1'b0, 1'b1);
        translate(48'h8000_0000_0000, rb, 2, 1'b1, 1'b1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 every result delivered once", exp_q.size(), 0);
        chk(req_ready && !mem_req_valid, "R10 idle at end", {62'h0, req_ready, mem_req_valid}, 64'h2);
        finish_up();
    end

endmodule